// File: doc/BRIEF.md
# Series Cell Harmonic-Compensation PWM Modulator

This block drives the three series floating H-bridge cells that sit on the outputs of a three-level converter switched at low frequency by a precomputed pulse pattern. For each phase it builds a cell voltage reference. It first derives the phase-to-load-neutral voltage of the pattern from the three leg states, with the common-mode part removed. It subtracts that voltage from the sinusoidal phase reference, which leaves the residual distortion to be cancelled. It then adds a host-supplied fundamental term that lies in phase with the load current and steers active power into or out of the cell capacitor.

The summed reference is expressed in carrier units, where the cell link voltage corresponds to the carrier peak. It is clipped to that range, and a sticky flag records any clipping. Two legs per cell compare the reference and its negation against a shared triangle carrier, which gives unipolar three-level cell output. Each leg drives a complementary switch pair with a dead time. The block also emits a one-cycle trigger at each carrier extreme, so that current sampling can be timed with the carrier.

Top module: `hbc_modulator`

## Requirements
- R1: Each leg state is a 2-bit code: 01 means upper rail (+1), 11 means lower rail (-1), and 00 or 10 means the neutral point (0). The pattern phase voltage of phase p is (2*s_p - s_q - s_r) * LEG_UNIT, where q and r are the other two phases.
- R2: The cell reference of each phase equals the sine reference, minus the pattern phase voltage, plus the fundamental term. The inputs are signed two's-complement values of RW bits, packed with phase a in the lowest bits.
- R3: The reference is saturated to the range -CAR_PEAK to +CAR_PEAK. A value exactly at either bound passes unchanged.
- R4: `ovm_flag` rises after any phase reference is clipped. It then stays high until reset, and references inside the range never set it.
- R5: The carrier is a triangle that steps by one per clock between -CAR_PEAK and +CAR_PEAK, with a period of 4*CAR_PEAK clocks. After reset it starts at -CAR_PEAK and counts upward.
- R6: The desired state of leg A is on when the reference is greater than the carrier. The desired state of leg B is on when the negated reference is greater than the carrier.
- R7: When a leg's desired state changes, both of its switches are off for DEAD clocks, after which the switch matching the desired state turns on. Over one carrier period, each switch is therefore on for its raw desired time minus DEAD, and never less than zero.
- R8: The upper and lower switches of a leg are never on together.
- R9: `sample_trig` is a one-clock pulse at each carrier extreme. The pulses are 2*CAR_PEAK clocks apart, and the first one appears in the clock after the first active edge following reset.
- R10: While reset is held, all switches are off and `sample_trig` and `ovm_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sin_ref | input | 3*RW | Signed sine references, phase a in the low bits |
| fund_ref | input | 3*RW | Signed fundamental power-steering terms |
| leg_code | input | 6 | Leg states of the three-level pattern, 2 bits per phase |
| gate | output | 12 | Per phase {B low, B high, A low, A high} |
| sample_trig | output | 1 | Carrier-synchronous sampling pulse |
| ovm_flag | output | 1 | Sticky overmodulation indication |

## Verification
The bench builds the block with CAR_PEAK = 8, LEG_UNIT = 8, DEAD = 3 and RW = 12. This gives a 32-clock carrier period, so every switch's on-time can be counted over whole periods and compared with a value derived from the carrier shape. Setting LEG_UNIT equal to the carrier peak reproduces the nominal ratio of cell voltage to main link voltage, so modest sine values cancel the pattern steps while larger ones reach both the exact saturation bounds and clipping. Because DEAD is larger than the one-clock notch that a full-scale reference leaves, the case where dead time swallows a short pulse is exercised.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  localparam int NPH = 3;

  typedef enum logic [1:0] {
    LEG_MID = 2'b00,
    LEG_TOP = 2'b01,
    LEG_ALT = 2'b10,
    LEG_BOT = 2'b11
  } leg_code_e;

  // Map a leg state code onto its rail level (-1, 0, +1).
  function automatic logic signed [2:0] leg_level(input logic [1:0] code);
    case (leg_code_e'(code))
      LEG_TOP: return 3'sd1;
      LEG_BOT: return -3'sd1;
      default: return 3'sd0;
    endcase
  endfunction

endpackage

// File: rtl/hbc_carrier.sv
module hbc_carrier #(
  parameter int PEAK = 256,
  parameter int CW   = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic signed [CW-1:0] car,
  output logic                 trig
);
  localparam logic signed [CW-1:0] PK = CW'(PEAK);
  localparam logic signed [CW-1:0] NK = CW'(-PEAK);

  logic up;

  always_ff @(posedge clk) begin
    if (rst) begin
      car  <= NK;
      up   <= 1'b1;
      trig <= 1'b0;
    end else begin
      trig <= (car == PK) || (car == NK);
      if (up) begin
        if (car == PK) begin
          car <= car - 1'b1;
          up  <= 1'b0;
        end else begin
          car <= car + 1'b1;
        end
      end else begin
        if (car == NK) begin
          car <= car + 1'b1;
          up  <= 1'b1;
        end else begin
          car <= car - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hbc_refcalc.sv
module hbc_refcalc
  import hbc_pkg::*;
#(
  parameter int RW   = 16,
  parameter int PEAK = 256,
  parameter int UNIT = 256,
  parameter int CW   = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [RW-1:0] sin_i,
  input  logic signed [RW-1:0] fund_i,
  input  logic [1:0]           code_own,
  input  logic [1:0]           code_nb1,
  input  logic [1:0]           code_nb2,
  output logic signed [CW-1:0] ref_o,
  output logic                 clip_o
);
  localparam int XW = RW + $clog2(UNIT + 1) + 4;
  localparam logic signed [XW-1:0] UNIT_X = XW'(UNIT);
  localparam logic signed [XW-1:0] PK_X   = XW'(PEAK);
  localparam logic signed [XW-1:0] NK_X   = XW'(-PEAK);

  logic signed [2:0]    lv_own, lv_nb1, lv_nb2;
  logic signed [XW-1:0] lvl_x, pat_x, sum_x, sat_x;
  logic                 clip_d;

  always_comb begin
    lv_own = leg_level(code_own);
    lv_nb1 = leg_level(code_nb1);
    lv_nb2 = leg_level(code_nb2);
    // Leg voltage minus the three-leg mean, scaled by 3 into LEG_UNIT steps
    lvl_x  = (XW'(lv_own) <<< 1) - XW'(lv_nb1) - XW'(lv_nb2);
    pat_x  = lvl_x * UNIT_X;
    sum_x  = XW'(sin_i) - pat_x + XW'(fund_i);
    clip_d = 1'b0;
    sat_x  = sum_x;
    if (sum_x > PK_X) begin
      sat_x  = PK_X;
      clip_d = 1'b1;
    end else if (sum_x < NK_X) begin
      sat_x  = NK_X;
      clip_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_o  <= '0;
      clip_o <= 1'b0;
    end else begin
      ref_o  <= sat_x[CW-1:0];
      clip_o <= clip_d;
    end
  end
endmodule

// File: rtl/hbc_deadtime.sv
module hbc_deadtime #(
  parameter int DEAD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic des,
  output logic sw_hi,
  output logic sw_lo
);
  localparam int TW = $clog2(DEAD + 1);
  localparam logic [TW-1:0] LOAD = TW'(DEAD - 1);

  logic          des_q;
  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      des_q <= 1'b0;
      tmr   <= LOAD;
      sw_hi <= 1'b0;
      sw_lo <= 1'b0;
    end else begin
      des_q <= des;
      if (des != des_q) begin
        tmr   <= LOAD;
        sw_hi <= 1'b0;
        sw_lo <= 1'b0;
      end else if (tmr != '0) begin
        tmr   <= tmr - 1'b1;
        sw_hi <= 1'b0;
        sw_lo <= 1'b0;
      end else begin
        sw_hi <= des;
        sw_lo <= ~des;
      end
    end
  end
endmodule

// File: rtl/hbc_modulator.sv
module hbc_modulator
  import hbc_pkg::*;
#(
  parameter int RW       = 16,
  parameter int CAR_PEAK = 256,
  parameter int LEG_UNIT = 256,
  parameter int DEAD     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPH*RW-1:0]   sin_ref,
  input  logic [NPH*RW-1:0]   fund_ref,
  input  logic [2*NPH-1:0]    leg_code,
  output logic [4*NPH-1:0]    gate,
  output logic                sample_trig,
  output logic                ovm_flag
);
  localparam int CW = $clog2(CAR_PEAK) + 2;

  logic signed [CW-1:0] car;
  logic [NPH-1:0]       clip_vec;

  hbc_carrier #(.PEAK(CAR_PEAK), .CW(CW)) u_car (
    .clk  (clk),
    .rst  (rst),
    .car  (car),
    .trig (sample_trig)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    localparam int Q = (p + 1) % NPH;
    localparam int R = (p + 2) % NPH;

    logic signed [CW-1:0] ref_q, nref;
    logic                 des_a, des_b;

    hbc_refcalc #(.RW(RW), .PEAK(CAR_PEAK), .UNIT(LEG_UNIT), .CW(CW)) u_ref (
      .clk      (clk),
      .rst      (rst),
      .sin_i    ($signed(sin_ref[p*RW +: RW])),
      .fund_i   ($signed(fund_ref[p*RW +: RW])),
      .code_own (leg_code[2*p +: 2]),
      .code_nb1 (leg_code[2*Q +: 2]),
      .code_nb2 (leg_code[2*R +: 2]),
      .ref_o    (ref_q),
      .clip_o   (clip_vec[p])
    );

    // Unipolar: leg B sees the mirrored reference against the same carrier
    always_comb begin
      nref  = -ref_q;
      des_a = ref_q > car;
      des_b = nref > car;
    end

    hbc_deadtime #(.DEAD(DEAD)) u_dt_a (
      .clk   (clk),
      .rst   (rst),
      .des   (des_a),
      .sw_hi (gate[4*p]),
      .sw_lo (gate[4*p+1])
    );

    hbc_deadtime #(.DEAD(DEAD)) u_dt_b (
      .clk   (clk),
      .rst   (rst),
      .des   (des_b),
      .sw_hi (gate[4*p+2]),
      .sw_lo (gate[4*p+3])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)            ovm_flag <= 1'b0;
    else if (|clip_vec) ovm_flag <= 1'b1;
  end
endmodule

// File: rtl/hbc_modulator_chk.sv
module hbc_modulator_chk #(
  parameter int NLEG     = 6,
  parameter int CAR_PEAK = 256
) (
  input logic              clk,
  input logic              rst,
  input logic [2*NLEG-1:0] gate,
  input logic              sample_trig,
  input logic              ovm_flag
);
  int unsigned gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (sample_trig) begin
      gap  <= 0;
      seen <= 1'b1;
    end else begin
      gap  <= gap + 1;
    end
  end

  p_trig_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    sample_trig |=> !sample_trig);

  p_trig_spacing_r9: assert property (@(posedge clk) disable iff (rst)
    (sample_trig && seen) |-> (gap == 2*CAR_PEAK - 1));

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    ovm_flag |=> ovm_flag);

  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> (gate == '0 && !sample_trig && !ovm_flag));

  for (genvar l = 0; l < NLEG; l++) begin : g_leg
    p_no_shoot_r8: assert property (@(posedge clk) disable iff (rst)
      !(gate[2*l] && gate[2*l+1]));

    p_gap_lo_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(gate[2*l+1]) |-> !$past(gate[2*l]));

    p_gap_hi_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(gate[2*l]) |-> !$past(gate[2*l+1]));
  end
endmodule

bind hbc_modulator hbc_modulator_chk #(.NLEG(2*hbc_pkg::NPH), .CAR_PEAK(CAR_PEAK)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .gate        (gate),
  .sample_trig (sample_trig),
  .ovm_flag    (ovm_flag)
);

// File: tb/hbc_modulator_test.sv
`timescale 1ns/1ps
module hbc_modulator_test;
  localparam int FS   = 8;
  localparam int UNIT = 8;
  localparam int DEAD = 3;
  localparam int RW   = 12;
  localparam int PER  = 4*FS;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [3*RW-1:0] sin_ref;
  logic [3*RW-1:0] fund_ref;
  logic [5:0]      leg_code;
  logic [11:0]     gate;
  logic            sample_trig;
  logic            ovm_flag;

  typedef logic [11:0][15:0] cnt_vec_t;
  cnt_vec_t exp_q[$];
  string    tag_q[$];

  int n_chk = 0;
  int n_fail = 0;
  bit model_ovm = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hbc_modulator #(.RW(RW), .CAR_PEAK(FS), .LEG_UNIT(UNIT), .DEAD(DEAD)) uut (
    .clk         (clk),
    .rst         (rst),
    .sin_ref     (sin_ref),
    .fund_ref    (fund_ref),
    .leg_code    (leg_code),
    .gate        (gate),
    .sample_trig (sample_trig),
    .ovm_flag    (ovm_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lvl(input logic [1:0] c);
    case (c)
      2'b01:   return 1;
      2'b11:   return -1;
      default: return 0;
    endcase
  endfunction

  // Raw on-time over one carrier period (R5 shape, R6 comparison)
  function automatic int rawh(input int r);
    int n = 0;
    for (int k = 0; k < PER; k++) begin
      int c;
      c = (k <= 2*FS) ? (-FS + k) : (3*FS - k);
      if (r > c) n++;
    end
    return n;
  endfunction

  // Switch on-time after dead time (R7)
  function automatic int on_cnt(input int raw);
    if (raw == 0)   return 0;
    if (raw == PER) return PER;
    return (raw > DEAD) ? raw - DEAD : 0;
  endfunction

  task automatic apply(input string tag, input int sa, input int sb, input int sc,
                       input int fa, input int fb, input int fc,
                       input logic [1:0] ca, input logic [1:0] cb, input logic [1:0] cc);
    int s[3];
    int f[3];
    int l[3];
    cnt_vec_t e;
    s[0] = sa; s[1] = sb; s[2] = sc;
    f[0] = fa; f[1] = fb; f[2] = fc;
    l[0] = lvl(ca); l[1] = lvl(cb); l[2] = lvl(cc);
    for (int p = 0; p < 3; p++) begin
      int pat, r, ha, hb;
      pat = (2*l[p] - l[(p+1)%3] - l[(p+2)%3]) * UNIT;
      r = s[p] - pat + f[p];
      if (r > FS) begin
        r = FS; model_ovm = 1'b1;
      end else if (r < -FS) begin
        r = -FS; model_ovm = 1'b1;
      end
      ha = rawh(r);
      hb = rawh(-r);
      e[4*p]   = 16'(on_cnt(ha));
      e[4*p+1] = 16'(on_cnt(PER - ha));
      e[4*p+2] = 16'(on_cnt(hb));
      e[4*p+3] = 16'(on_cnt(PER - hb));
    end
    @(negedge clk);
    sin_ref  = {RW'(sc), RW'(sb), RW'(sa)};
    fund_ref = {RW'(fc), RW'(fb), RW'(fa)};
    leg_code = {cc, cb, ca};
    repeat (3*PER) @(negedge clk);
    tag_q.push_back(tag);
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
    @(negedge clk);
    chk({tag, " R4 overmodulation flag"}, int'(ovm_flag), int'(model_ovm));
  endtask

  // Monitor: one full carrier period of switch activity per expected item
  initial begin
    forever begin
      int cnt[12];
      int tr;
      int both;
      cnt_vec_t e;
      wait (exp_q.size() > 0);
      do @(negedge clk); while (!sample_trig);
      for (int g = 0; g < 12; g++) cnt[g] = 0;
      tr = 0;
      both = 0;
      for (int k = 0; k < PER; k++) begin
        if (k > 0) @(negedge clk);
        for (int g = 0; g < 12; g++) cnt[g] += int'(gate[g]);
        tr += int'(sample_trig);
        for (int lg = 0; lg < 6; lg++)
          if (gate[2*lg] && gate[2*lg+1]) both++;
      end
      e = exp_q[0];
      for (int g = 0; g < 12; g++)
        chk($sformatf("%s R6 R7 phase %0d switch %0d on-time", tag_q[0], g/4, g%4),
            cnt[g], int'(e[g]));
      chk({tag_q[0], " R9 triggers per period"}, tr, 2);
      chk({tag_q[0], " R8 shoot-through cycles"}, both, 0);
      void'(tag_q.pop_front());
      void'(exp_q.pop_front());
    end
  end

  initial begin
    sin_ref  = '0;
    fund_ref = '0;
    leg_code = '0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 switches off in reset", int'(gate), 0);
    chk("R10 trigger low in reset", int'(sample_trig), 0);
    chk("R10 flag low in reset", int'(ovm_flag), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R5 R9 first trigger at starting valley", int'(sample_trig), 1);
    begin
      int k = 0;
      do begin
        @(negedge clk);
        k++;
      end while (!sample_trig && k < 4*PER);
      chk("R9 trigger spacing", k, 2*FS);
    end

    apply("R6 zero reference",          0,   0,   0,  0,  0,  0, 2'b00, 2'b00, 2'b00);
    apply("R1 R2 pattern top/bot/mid",  20, -22,  3,  1,  0, -2, 2'b01, 2'b11, 2'b00);
    apply("R1 R2 rotated states",       6,  25, -30,  0, -4,  2, 2'b00, 2'b01, 2'b11);
    apply("R1 code 10 as neutral",     -4,  12,  -9,  0,  0,  0, 2'b10, 2'b01, 2'b00);
    apply("R3 exact bounds",            8,  -8,   0,  0,  0,  0, 2'b00, 2'b00, 2'b00);
    apply("R3 clipping",               30, -30,   0,  0,  0,  0, 2'b00, 2'b00, 2'b00);
    apply("R4 flag held after clip",    0,   0,   0,  0,  3,  0, 2'b00, 2'b00, 2'b00);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule